// File: doc/BRIEF.md
# Address Range Access Checker

This block sits in front of a bus target and decides for every request whether it may pass. Software programs a fixed number of address windows. Each window has a lower and an upper address, a permission word and two role masks. A request carries an address, a write flag, an instruction-fetch flag and a 16-bit role vector. The block searches the windows in index order. The first enabled window that contains the address decides the outcome. That window must permit the access kind, and the request's role vector must share at least one bit with the window's role mask for that access kind.

A granted read returns the downstream data. A denied request returns an error with all-zero data. An 8-bit multi-bit bypass code forces every request to be granted. Every denial that occurs without the bypass raises a saturating counter and records which window denied the request; the value N is recorded when no window matched. Each window has a 4-bit multi-bit lock. Writing the closed code to it freezes that window's configuration until reset.

Configuration uses a simple write/read port. The port address is {status select, window index, field}. The response to a request and the data for a configuration read both appear one clock after the request or read.

Top module: `addr_range_guard`

## Requirements
- R1: After reset every window is disabled, its bounds, permission and masks read 0, its lock reads 0x6 (open), and the status word reads 0. A request issued in this state is denied.
- R2: A window matches a request when its permission enable bit (bit 0) is 1 and lower <= address < upper. The upper bound is exclusive.
- R3: A write needs permission bit 2. A read with the instruction flag set needs bit 3. A read with the instruction flag clear needs bit 1. The instruction flag has no effect on a write. A window whose enable bit is 0 never matches.
- R4: Reads and instruction fetches pass the role check when request role AND read mask (field 3) is nonzero. Writes use the write mask (field 4) in the same way.
- R5: When several enabled windows match, only the lowest-index one decides, even if a higher window would grant.
- R6: A granted read returns the request's downstream data. A granted write returns zero data. A denied request raises the error output and returns zero data. Grant and error are never both set.
- R7: For each request cycle, the response (valid, grant, error, data) appears exactly one clock later.
- R8: While the bypass input equals 0x96, every request is granted and the deny counter and logged index do not change. Any other bypass value has no effect.
- R9: Each denial outside bypass increments the deny counter (status bits 7:0). The counter saturates at 255. The denial also logs the deciding window index, or N when no window matched, in status bits 18:16.
- R10: Writing 0x9 to a window's lock field (field 5) closes the lock. The lock then reads 0x9, and later writes to that window's lower bound, upper bound, permission and masks are ignored. Writing any other value has no effect on the lock. Only reset reopens it.
- R11: Configuration fields: 0 lower, 1 upper, 2 permission, 3 read mask, 4 write mask, 5 lock. The configuration address is {bit 5 status select, bits 4:3 window, bits 2:0 field}. Read data appears one clock after cfg_re.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bypass_code | input | 8 | Multi-bit bypass; 0x96 grants everything |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 32 | Request address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_instr | input | 1 | Instruction-fetch flag for reads |
| req_role | input | 16 | Requester role vector |
| req_rdata | input | 32 | Downstream read data for this request |
| rsp_valid | output | 1 | Response present |
| rsp_grant | output | 1 | Request granted |
| rsp_error | output | 1 | Request denied |
| rsp_rdata | output | 32 | Returned read data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_re | input | 1 | Configuration read strobe |
| cfg_addr | input | 6 | Configuration address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |

## Verification
There is one register stage between the request inputs and the response outputs. The bench therefore drives a request on a falling edge and compares grant, error and data on the next falling edge, one rising edge later. Configuration writes take effect at the rising edge after they are driven, so the earliest request or read that can see them starts at the following falling edge. Configuration read data is compared one edge after cfg_re. Status is read back only after the denials it should count have completed, and the expected counter and index are updated in the bench at the same point as each denial.

// File: rtl/arg_pkg.sv
package arg_pkg;
    localparam logic [7:0] BYPASS_ON = 8'h96;
    localparam logic [3:0] LOCK_OPEN = 4'h6;
    localparam logic [3:0] LOCK_SHUT = 4'h9;

    typedef enum logic [2:0] {
        FLD_LOWER = 3'd0,
        FLD_UPPER = 3'd1,
        FLD_PERM  = 3'd2,
        FLD_RDMSK = 3'd3,
        FLD_WRMSK = 3'd4,
        FLD_LOCK  = 3'd5
    } field_e;

    localparam int PB_EN = 0;
    localparam int PB_RD = 1;
    localparam int PB_WR = 2;
    localparam int PB_EX = 3;
endpackage

// File: rtl/arg_range_slot.sv
module arg_range_slot #(
    parameter int AW    = 32,
    parameter int ROLEW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_field,
    input  logic [31:0]      wr_data,
    input  logic [2:0]       rd_field,
    output logic [31:0]      rd_val,
    input  logic [AW-1:0]    req_addr,
    input  logic             req_we,
    input  logic             req_instr,
    input  logic [ROLEW-1:0] req_role,
    output logic             hit,
    output logic             pass
);
    import arg_pkg::*;

    typedef struct packed {
        logic [AW-1:0]    lower;
        logic [AW-1:0]    upper;
        logic [3:0]       perm;
        logic [ROLEW-1:0] rdmsk;
        logic [ROLEW-1:0] wrmsk;
        logic             shut;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            if (!s_q.shut) begin
                case (wr_field)
                    FLD_LOWER: s_d.lower = wr_data[AW-1:0];
                    FLD_UPPER: s_d.upper = wr_data[AW-1:0];
                    FLD_PERM:  s_d.perm  = wr_data[3:0];
                    FLD_RDMSK: s_d.rdmsk = wr_data[ROLEW-1:0];
                    FLD_WRMSK: s_d.wrmsk = wr_data[ROLEW-1:0];
                    FLD_LOCK:  if (wr_data[3:0] == LOCK_SHUT) s_d.shut = 1'b1;
                    default:   ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    logic perm_ok;
    logic role_ok;

    always_comb begin
        hit = s_q.perm[PB_EN] && (req_addr >= s_q.lower) && (req_addr < s_q.upper);
        if (req_we)         perm_ok = s_q.perm[PB_WR];
        else if (req_instr) perm_ok = s_q.perm[PB_EX];
        else                perm_ok = s_q.perm[PB_RD];
        role_ok = |(req_role & (req_we ? s_q.wrmsk : s_q.rdmsk));
        pass    = perm_ok && role_ok;
    end

    always_comb begin
        case (rd_field)
            FLD_LOWER: rd_val = 32'(s_q.lower);
            FLD_UPPER: rd_val = 32'(s_q.upper);
            FLD_PERM:  rd_val = 32'(s_q.perm);
            FLD_RDMSK: rd_val = 32'(s_q.rdmsk);
            FLD_WRMSK: rd_val = 32'(s_q.wrmsk);
            FLD_LOCK:  rd_val = 32'(s_q.shut ? LOCK_SHUT : LOCK_OPEN);
            default:   rd_val = '0;
        endcase
    end

    // R10: a closed window keeps its configuration across writes
    assert_locked_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.shut && wr_en) |=> ($stable(s_q.lower) && $stable(s_q.upper) &&
                                 $stable(s_q.perm) && $stable(s_q.rdmsk) && $stable(s_q.wrmsk)));

    // R10: the lock never reopens without reset
    assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.shut |=> s_q.shut);
endmodule

// File: rtl/arg_prio_pick.sv
module arg_prio_pick #(
    parameter int N     = 4,
    parameter int IDXW1 = 3
) (
    input  logic [N-1:0]     hit,
    input  logic [N-1:0]     pass,
    output logic             found,
    output logic [IDXW1-1:0] idx,
    output logic             pass_sel,
    output logic [N-1:0]     first
);
    always_comb begin
        found    = 1'b0;
        idx      = IDXW1'(N);
        pass_sel = 1'b0;
        first    = '0;
        for (int i = 0; i < N; i++) begin
            if (!found && hit[i]) begin
                found    = 1'b1;
                idx      = IDXW1'(i);
                pass_sel = pass[i];
                first[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/arg_deny_log.sv
module arg_deny_log #(
    parameter int CNTW  = 8,
    parameter int IDXW1 = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             deny_ev,
    input  logic [IDXW1-1:0] deny_idx,
    output logic [CNTW-1:0]  cnt,
    output logic [IDXW1-1:0] last_idx
);
    typedef struct packed {
        logic [CNTW-1:0]  cnt;
        logic [IDXW1-1:0] idx;
    } log_t;

    log_t l_d, l_q;

    always_comb begin
        l_d = l_q;
        if (deny_ev) begin
            if (l_q.cnt != '1) l_d.cnt = l_q.cnt + 1'b1;
            l_d.idx = deny_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign cnt      = l_q.cnt;
    assign last_idx = l_q.idx;

    // R9: counter holds at its maximum
    assert_cnt_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (l_q.cnt == '1) |=> (l_q.cnt == '1));

    // R9: a denial below the maximum raises the count by one
    assert_cnt_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (deny_ev && l_q.cnt != '1) |=> (l_q.cnt == $past(l_q.cnt) + 1'b1));

    // R9: without a denial nothing changes
    assert_cnt_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !deny_ev |=> ($stable(l_q.cnt) && $stable(l_q.idx)));
endmodule

// File: rtl/addr_range_guard.sv
module addr_range_guard #(
    parameter int N     = 4,
    parameter int AW    = 32,
    parameter int ROLEW = 16,
    parameter int CNTW  = 8,
    localparam int IDXW  = (N > 1) ? $clog2(N) : 1,
    localparam int IDXW1 = $clog2(N + 1),
    localparam int CAW   = IDXW + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       bypass_code,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_addr,
    input  logic             req_we,
    input  logic             req_instr,
    input  logic [ROLEW-1:0] req_role,
    input  logic [31:0]      req_rdata,
    output logic             rsp_valid,
    output logic             rsp_grant,
    output logic             rsp_error,
    output logic [31:0]      rsp_rdata,
    input  logic             cfg_we,
    input  logic             cfg_re,
    input  logic [CAW-1:0]   cfg_addr,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata
);
    import arg_pkg::*;

    logic            cfg_stat;
    logic [IDXW-1:0] cfg_slot;
    logic [2:0]      cfg_field;

    assign cfg_stat  = cfg_addr[CAW-1];
    assign cfg_slot  = cfg_addr[IDXW+2:3];
    assign cfg_field = cfg_addr[2:0];

    logic [N-1:0] hit, pass;
    logic [31:0]  slot_rd [N];

    for (genvar g = 0; g < N; g++) begin : g_slot
        logic wr_sel;
        assign wr_sel = cfg_we && !cfg_stat && (int'(cfg_slot) == g);
        arg_range_slot #(.AW(AW), .ROLEW(ROLEW)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_sel),
            .wr_field (cfg_field),
            .wr_data  (cfg_wdata),
            .rd_field (cfg_field),
            .rd_val   (slot_rd[g]),
            .req_addr (req_addr),
            .req_we   (req_we),
            .req_instr(req_instr),
            .req_role (req_role),
            .hit      (hit[g]),
            .pass     (pass[g])
        );
    end

    logic             found, pass_sel;
    logic [IDXW1-1:0] pick_idx;
    logic [N-1:0]     first;

    arg_prio_pick #(.N(N), .IDXW1(IDXW1)) u_pick (
        .hit     (hit),
        .pass    (pass),
        .found   (found),
        .idx     (pick_idx),
        .pass_sel(pass_sel),
        .first   (first)
    );

    logic bypass, grant, deny_ev;
    assign bypass  = (bypass_code == BYPASS_ON);
    assign grant   = bypass || (found && pass_sel);
    assign deny_ev = req_valid && !grant;

    logic [CNTW-1:0]  deny_cnt;
    logic [IDXW1-1:0] deny_last;

    arg_deny_log #(.CNTW(CNTW), .IDXW1(IDXW1)) u_log (
        .clk     (clk),
        .rst_n   (rst_n),
        .deny_ev (deny_ev),
        .deny_idx(pick_idx),
        .cnt     (deny_cnt),
        .last_idx(deny_last)
    );

    typedef struct packed {
        logic        valid;
        logic        grant;
        logic        error;
        logic [31:0] rdata;
        logic [31:0] cfg_rdata;
    } top_t;

    top_t t_d, t_q;
    logic [31:0] cfg_val;

    always_comb begin
        if (cfg_stat)              cfg_val = 32'(deny_cnt) | (32'(deny_last) << 16);
        else if (int'(cfg_slot) < N) cfg_val = slot_rd[cfg_slot];
        else                       cfg_val = '0;
    end

    always_comb begin
        t_d       = t_q;
        t_d.valid = req_valid;
        t_d.grant = req_valid && grant;
        t_d.error = req_valid && !grant;
        t_d.rdata = (req_valid && grant && !req_we) ? req_rdata : '0;
        if (cfg_re) t_d.cfg_rdata = cfg_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign rsp_valid = t_q.valid;
    assign rsp_grant = t_q.grant;
    assign rsp_error = t_q.error;
    assign rsp_rdata = t_q.rdata;
    assign cfg_rdata = t_q.cfg_rdata;

    // R6: a denied response never carries data
    assert_err_zero_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_error) |-> (rsp_rdata == '0));

    // R6: exactly one of grant or error on each response
    assert_grant_xor_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_grant ^ rsp_error));

    // R7: a response follows every request one clock later
    assert_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R8: bypass leaves the deny log untouched
    assert_bypass_nocount_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && bypass) |=> ($stable(deny_cnt) && $stable(deny_last)));

    // R5: at most one window is picked and it is a matching one
    assert_pick_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(first) && ((first & ~hit) == '0));
endmodule

// File: tb/addr_range_guard_test.sv
module addr_range_guard_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bypass_code = 8'h00;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_we = 1'b0;
    logic        req_instr = 1'b0;
    logic [15:0] req_role = '0;
    logic [31:0] req_rdata = '0;
    logic        rsp_valid, rsp_grant, rsp_error;
    logic [31:0] rsp_rdata;
    logic        cfg_we = 1'b0;
    logic        cfg_re = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;

    int compared = 0;
    int mismatched = 0;
    int exp_cnt = 0;
    int exp_idx = 0;

    always #5 clk = ~clk;

    addr_range_guard uut (
        .clk(clk), .rst_n(rst_n), .bypass_code(bypass_code),
        .req_valid(req_valid), .req_addr(req_addr), .req_we(req_we),
        .req_instr(req_instr), .req_role(req_role), .req_rdata(req_rdata),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_error(rsp_error),
        .rsp_rdata(rsp_rdata), .cfg_we(cfg_we), .cfg_re(cfg_re),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    function automatic logic [5:0] ra(input int r, input int f);
        ra = {1'b0, 2'(r), 3'(f)};
    endfunction

    localparam logic [5:0] STAT = 6'h20;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
        @(negedge clk);
        cfg_re = 1'b1; cfg_addr = a;
        @(negedge clk);
        cfg_re = 1'b0;
        check(tag, cfg_rdata, exp);
    endtask

    task automatic stat_chk(input string tag);
        cfg_chk(tag, STAT, 32'(exp_cnt) | (32'(exp_idx) << 16));
    endtask

    task automatic do_req(input string tag, input logic [31:0] a, input logic we,
                          input logic ins, input logic [15:0] role,
                          input logic exp_grant, input int deny_idx);
        logic [31:0] d;
        d = a ^ 32'hA5A5_0000;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_we = we; req_instr = ins;
        req_role = role; req_rdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid"}, 32'(rsp_valid), 32'd1);
        check({tag, " grant"}, 32'(rsp_grant), 32'(exp_grant));
        check({tag, " error"}, 32'(rsp_error), 32'(!exp_grant));
        check({tag, " data"}, rsp_rdata, (exp_grant && !we) ? d : 32'd0);
        if (!exp_grant) begin
            if (exp_cnt < 255) exp_cnt++;
            exp_idx = deny_idx;
        end
    endtask

    task automatic t_reset;
        cfg_chk("R1 perm0", ra(0, 2), 0);
        cfg_chk("R1 lower0", ra(0, 0), 0);
        cfg_chk("R1 lock0", ra(0, 5), 32'h6);
        stat_chk("R1 status");
        do_req("R1 req", 32'h10, 1'b0, 1'b0, 16'hFFFF, 1'b0, 4);
        stat_chk("R1 status after deny");
    endtask

    task automatic t_setup;
        cfg_wr(ra(0, 0), 32'h1000); cfg_wr(ra(0, 1), 32'h2000);
        cfg_wr(ra(0, 2), 32'h7);    cfg_wr(ra(0, 3), 32'hFFFF); cfg_wr(ra(0, 4), 32'hFFFF);
        cfg_wr(ra(1, 0), 32'h1800); cfg_wr(ra(1, 1), 32'h3000);
        cfg_wr(ra(1, 2), 32'hB);    cfg_wr(ra(1, 3), 32'h0003); cfg_wr(ra(1, 4), 32'hFFFF);
        cfg_wr(ra(2, 0), 32'h4000); cfg_wr(ra(2, 1), 32'h5000);
        cfg_wr(ra(2, 2), 32'h5);    cfg_wr(ra(2, 3), 32'hFFFF); cfg_wr(ra(2, 4), 32'h0010);
        cfg_wr(ra(3, 0), 32'h6000); cfg_wr(ra(3, 1), 32'h7000);
        cfg_wr(ra(3, 2), 32'hE);    cfg_wr(ra(3, 3), 32'hFFFF); cfg_wr(ra(3, 4), 32'hFFFF);
        cfg_chk("R11 upper1", ra(1, 1), 32'h3000);
        cfg_chk("R11 rdmask1", ra(1, 3), 32'h0003);
        cfg_chk("R11 wrmask2", ra(2, 4), 32'h0010);
        cfg_chk("R11 field6", ra(1, 6), 32'h0);
    endtask

    task automatic t_bounds;
        do_req("R2 at lower", 32'h1000, 0, 0, 16'h1, 1, 0);
        do_req("R2 last byte", 32'h1FFF, 0, 0, 16'h1, 1, 0);
        do_req("R2 below", 32'h0FFF, 0, 0, 16'h1, 0, 4);
        do_req("R2 upper excl", 32'h3000, 0, 0, 16'h1, 0, 4);
        do_req("R2 win1 top", 32'h2FFF, 0, 0, 16'h1, 1, 0);
        do_req("R3 disabled win", 32'h6000, 0, 0, 16'h1, 0, 4);
        stat_chk("R9 status none");
    endtask

    task automatic t_perm;
        do_req("R3 write ok", 32'h1100, 1, 0, 16'h1, 1, 0);
        do_req("R3 write instr ignored", 32'h1104, 1, 1, 16'h1, 1, 0);
        do_req("R3 exec ok", 32'h2000, 0, 1, 16'h1, 1, 0);
        do_req("R3 write no perm", 32'h2000, 1, 0, 16'h1, 0, 1);
        stat_chk("R9 status win1");
        do_req("R3 read no perm", 32'h4000, 0, 0, 16'h1, 0, 2);
        stat_chk("R9 status win2");
    endtask

    task automatic t_roles;
        do_req("R4 read role miss", 32'h2800, 0, 0, 16'h4, 0, 1);
        do_req("R4 read role hit", 32'h2800, 0, 0, 16'h2, 1, 0);
        do_req("R4 exec role miss", 32'h2800, 0, 1, 16'h10, 0, 1);
        do_req("R4 write role hit", 32'h4000, 1, 0, 16'h10, 1, 0);
        do_req("R4 write role miss", 32'h4000, 1, 0, 16'h20, 0, 2);
        stat_chk("R9 status roles");
    endtask

    task automatic t_prio;
        do_req("R5 low wins deny", 32'h1800, 0, 1, 16'h1, 0, 0);
        stat_chk("R5 status idx0");
        do_req("R5 high only", 32'h2000, 0, 1, 16'h1, 1, 0);
    endtask

    task automatic t_bypass;
        bypass_code = 8'h96;
        do_req("R8 bypass outside", 32'h0, 0, 0, 16'h0, 1, 0);
        do_req("R8 bypass write", 32'h6000, 1, 0, 16'h0, 1, 0);
        stat_chk("R8 status frozen");
        bypass_code = 8'h69;
        do_req("R8 other code", 32'h0, 0, 0, 16'h0, 0, 4);
        stat_chk("R8 status counted");
        bypass_code = 8'h00;
    endtask

    task automatic t_lock;
        cfg_wr(ra(2, 5), 32'h3);
        cfg_chk("R10 bad code open", ra(2, 5), 32'h6);
        cfg_wr(ra(2, 0), 32'h4400);
        cfg_chk("R10 open write", ra(2, 0), 32'h4400);
        cfg_wr(ra(0, 5), 32'h9);
        cfg_chk("R10 lock reads shut", ra(0, 5), 32'h9);
        cfg_wr(ra(0, 0), 32'h0);
        cfg_wr(ra(0, 2), 32'h0);
        cfg_chk("R10 lower kept", ra(0, 0), 32'h1000);
        cfg_chk("R10 perm kept", ra(0, 2), 32'h7);
        do_req("R10 still denied", 32'h0800, 0, 0, 16'h1, 0, 4);
        do_req("R10 still granted", 32'h1000, 0, 0, 16'h1, 1, 0);
        cfg_wr(ra(0, 5), 32'h6);
        cfg_chk("R10 no reopen", ra(0, 5), 32'h9);
        cfg_wr(ra(1, 3), 32'hFFFF);
        cfg_chk("R10 other win open", ra(1, 3), 32'hFFFF);
    endtask

    task automatic t_saturate;
        for (int i = 0; i < 260; i++) begin
            @(negedge clk);
            req_valid = 1'b1; req_addr = 32'h0; req_we = 1'b0; req_role = 16'h1;
        end
        @(negedge clk);
        req_valid = 1'b0;
        exp_cnt = 255; exp_idx = 4;
        stat_chk("R9 saturated");
        do_req("R9 deny at max", 32'h0, 0, 0, 16'h1, 0, 4);
        stat_chk("R9 still max");
    endtask

    task automatic t_rereset;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        exp_cnt = 0; exp_idx = 0;
        cfg_chk("R10 reset reopens", ra(0, 5), 32'h6);
        cfg_wr(ra(0, 0), 32'h800);
        cfg_chk("R10 write after reset", ra(0, 0), 32'h800);
        stat_chk("R1 status after reset");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL R7 watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_setup();
        t_bounds();
        t_perm();
        t_roles();
        t_prio();
        t_bypass();
        t_lock();
        t_saturate();
        t_rereset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule